// File: doc/BRIEF.md
# Dual Alarm Comparator Channel

This block watches the stream of corrected main-sensor results and drives two digital alarm pins. Each of the two channels holds its own limit, hysteresis, direction, and separate debounce counts for switching on and switching off. A channel can also run as a window comparator, flagging values that fall inside a band above its limit. Results tagged as temperature readings pass through the stream but are never compared.

Samples arrive on a valid/ready stream. The block never applies back-pressure: `s_ready` is high whenever reset is released, and a sample is taken on every clock edge where `s_valid` is high. Configuration, the slave-select hold, the diagnostic input and the safe level are plain level inputs. When the second alarm pin is lent to the serial interface as a slave select, that channel is held inactive. A diagnostic error overrides both pins with a programmed safe level.

Top module: `dual_alarm_cmp`

## Requirements
- R1: Two channels run independently. Each uses its own configuration fields and drives only its own bit of `alarm` (bit 0 is channel 0, bit 1 is channel 1). After reset both bits are 0 and `s_ready` is 1.
- R2: With `win_en`=0 and `dir_low`=0, an inactive channel turns on when the value is greater than `thr`. An active channel turns off when the value is less than `thr - hyst`.
- R3: With `win_en`=0 and `dir_low`=1, an inactive channel turns on when the value is less than `thr`. An active channel turns off when the value is greater than `thr + hyst`.
- R4: With `win_en`=1, an inactive channel turns on when `thr <= value <= thr + win_width`. An active channel turns off when the value is below `thr - hyst` or above `thr + win_width + hyst`. `dir_low` is ignored in this mode.
- R5: The block ignores a sample with `s_is_temp`=1. An alarm bit changes only on the clock edge that accepts a main-sensor sample, or through R8 or R9.
- R6: An inactive channel turns on at the edge of the (`on_dly`+1)th consecutive sample that meets its turn-on condition. A sample that does not meet the condition restarts the count.
- R7: An active channel turns off at the edge of the (`off_dly`+1)th consecutive sample that meets its turn-off condition. A sample that does not meet the condition restarts the count.
- R8: While `ss_hold`=1, `alarm[1]` is 0. Channel 1's state and counter are cleared, so the channel restarts as inactive after `ss_hold` is released.
- R9: While `diag_err`=1, `alarm` equals `safe_lvl`. Internal tracking continues during this time.
- R10: With `signed_en`=1, the sample and `thr` are read as two's complement values. With `signed_en`=0 they are read as unsigned. `hyst` and `win_width` are always unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Always 1 after reset (no back-pressure) |
| s_data | input | W (15) | Corrected sample value |
| s_is_temp | input | 1 | Sample is a temperature result (ignored) |
| signed_en | input | 1 | Read sample and limits as two's complement |
| thr | input | 2 x W | Per-channel limit |
| hyst | input | 2 x W | Per-channel hysteresis (unsigned) |
| win_width | input | 2 x W | Per-channel window width (unsigned) |
| dir_low | input | 2 | Per-channel direction: 1 = alarm below limit |
| win_en | input | 2 | Per-channel window mode enable |
| on_dly | input | 2 x DW (6) | Per-channel turn-on sample count |
| off_dly | input | 2 x DW (6) | Per-channel turn-off sample count |
| ss_hold | input | 1 | Channel 1 pin is used as slave select |
| diag_err | input | 1 | Diagnostic error |
| safe_lvl | input | 2 | Levels forced onto the pins on error |
| alarm | output | 2 | Alarm pins |

## Verification
The checker confirms three rules on every cycle:
- the diagnostic override always shows the safe level;
- the held channel stays low;
- no alarm bit moves in a cycle without an accepted main-sensor sample, unless the override or the hold is active.

Two further groups of behaviour are reached only through the bench's scenarios, where a scoreboard model predicts each pin after every sample:
- the limit arithmetic of each mode, including the exact hysteresis edges, the window bounds and the signed-versus-unsigned reading;
- the debounce counts and their restart on an interrupted run.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  typedef enum logic [1:0] {
    CMP_ABOVE  = 2'd0,
    CMP_BELOW  = 2'd1,
    CMP_WINDOW = 2'd2
  } cmp_mode_e;

  function automatic cmp_mode_e pick_mode(input logic win, input logic low);
    if (win)      return CMP_WINDOW;
    else if (low) return CMP_BELOW;
    else          return CMP_ABOVE;
  endfunction
endpackage

// File: rtl/alarm_cmp.sv
module alarm_cmp
  import alarm_pkg::*;
#(
  parameter int W = 15
) (
  input  logic [W-1:0] value,
  input  logic [W-1:0] limit,
  input  logic [W-1:0] hyst,
  input  logic [W-1:0] width,
  input  logic         signed_en,
  input  cmp_mode_e    mode,
  input  logic         active,
  output logic         flip
);
  localparam int EW = W + 3;

  logic signed [EW-1:0] v_x, t_x, h_x, w_x;
  logic signed [EW-1:0] lo_edge, hi_edge, top_edge, top_rel;

  always_comb begin
    v_x = signed_en ? EW'($signed(value)) : $signed({3'b000, value});
    t_x = signed_en ? EW'($signed(limit)) : $signed({3'b000, limit});
    h_x = $signed({3'b000, hyst});
    w_x = $signed({3'b000, width});
    lo_edge  = t_x - h_x;
    hi_edge  = t_x + h_x;
    top_edge = t_x + w_x;
    top_rel  = top_edge + h_x;
  end

  always_comb begin
    flip = 1'b0;
    unique case (mode)
      CMP_ABOVE:  flip = active ? (v_x < lo_edge) : (v_x > t_x);
      CMP_BELOW:  flip = active ? (v_x > hi_edge) : (v_x < t_x);
      CMP_WINDOW: flip = active ? ((v_x < lo_edge) || (v_x > top_rel))
                                : ((v_x >= t_x) && (v_x <= top_edge));
      default:    flip = 1'b0;
    endcase
  end
endmodule

// File: rtl/alarm_dly.sv
module alarm_dly #(
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          flip,
  input  logic [DW-1:0] on_cnt,
  input  logic [DW-1:0] off_cnt,
  output logic          state
);
  logic [DW-1:0] run;
  logic [DW-1:0] lim;

  assign lim = state ? off_cnt : on_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= 1'b0;
      run   <= '0;
    end else if (clr) begin
      state <= 1'b0;
      run   <= '0;
    end else if (step) begin
      if (flip) begin
        if (run == lim) begin
          state <= ~state;
          run   <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/alarm_chan.sv
module alarm_chan
  import alarm_pkg::*;
#(
  parameter int W  = 15,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [W-1:0]  value,
  input  logic          signed_en,
  input  logic [W-1:0]  limit,
  input  logic [W-1:0]  hyst,
  input  logic [W-1:0]  width,
  input  logic          low,
  input  logic          win,
  input  logic [DW-1:0] on_cnt,
  input  logic [DW-1:0] off_cnt,
  output logic          state
);
  cmp_mode_e mode;
  logic      flip;

  assign mode = pick_mode(win, low);

  alarm_cmp #(.W(W)) u_cmp (
    .value(value), .limit(limit), .hyst(hyst), .width(width),
    .signed_en(signed_en), .mode(mode), .active(state), .flip(flip)
  );

  alarm_dly #(.DW(DW)) u_dly (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(step), .flip(flip),
    .on_cnt(on_cnt), .off_cnt(off_cnt), .state(state)
  );
endmodule

// File: rtl/dual_alarm_cmp.sv
module dual_alarm_cmp #(
  parameter int W   = 15,
  parameter int DW  = 6,
  parameter int NCH = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [W-1:0]           s_data,
  input  logic                   s_is_temp,
  input  logic                   signed_en,
  input  logic [NCH-1:0][W-1:0]  thr,
  input  logic [NCH-1:0][W-1:0]  hyst,
  input  logic [NCH-1:0][W-1:0]  win_width,
  input  logic [NCH-1:0]         dir_low,
  input  logic [NCH-1:0]         win_en,
  input  logic [NCH-1:0][DW-1:0] on_dly,
  input  logic [NCH-1:0][DW-1:0] off_dly,
  input  logic                   ss_hold,
  input  logic                   diag_err,
  input  logic [NCH-1:0]         safe_lvl,
  output logic [NCH-1:0]         alarm
);
  localparam int HELD = NCH - 1;

  logic           take;
  logic [NCH-1:0] st;
  logic [NCH-1:0] gated;

  assign s_ready = rst_n;
  assign take    = s_valid && s_ready && !s_is_temp;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic clr_c;
    if (c == HELD) begin : g_held
      assign clr_c    = ss_hold;
      assign gated[c] = st[c] && !ss_hold;
    end else begin : g_free
      assign clr_c    = 1'b0;
      assign gated[c] = st[c];
    end

    alarm_chan #(.W(W), .DW(DW)) u_chan (
      .clk(clk), .rst_n(rst_n), .clr(clr_c), .step(take),
      .value(s_data), .signed_en(signed_en),
      .limit(thr[c]), .hyst(hyst[c]), .width(win_width[c]),
      .low(dir_low[c]), .win(win_en[c]),
      .on_cnt(on_dly[c]), .off_cnt(off_dly[c]), .state(st[c])
    );
  end

  assign alarm = diag_err ? safe_lvl : gated;
endmodule

// File: rtl/alarm_chk.sv
module alarm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_valid,
  input logic       s_is_temp,
  input logic       ss_hold,
  input logic       diag_err,
  input logic [1:0] safe_lvl,
  input logic [1:0] alarm
);
  logic acc;
  assign acc = s_valid && !s_is_temp;

  AST_DIAG_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    diag_err |-> (alarm == safe_lvl)); // R9

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_hold && !diag_err) |-> !alarm[1]); // R8

  AST_CH0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !diag_err) |=> (diag_err || $stable(alarm[0]))); // R5

  AST_CH1_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !diag_err && !ss_hold) |=> (diag_err || ss_hold || $stable(alarm[1]))); // R5
endmodule

bind dual_alarm_cmp alarm_chk u_alarm_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_is_temp(s_is_temp),
  .ss_hold(ss_hold), .diag_err(diag_err), .safe_lvl(safe_lvl[1:0]),
  .alarm(alarm[1:0])
);

// File: tb/tb_dual_alarm_cmp.sv
module tb_dual_alarm_cmp;
  localparam int W = 15, DW = 6;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_is_temp = 0, signed_en = 0;
  logic s_ready;
  logic [W-1:0] s_data = '0;
  logic [1:0][W-1:0] thr = '0, hyst = '0, win_width = '0;
  logic [1:0] dir_low = '0, win_en = '0, safe_lvl = '0, alarm;
  logic [1:0][DW-1:0] on_dly = '0, off_dly = '0;
  logic ss_hold = 0, diag_err = 0;

  int checks = 0, errors = 0;
  logic m_st [2];
  int   m_cnt [2];
  logic [1:0] q_exp [$];
  string      q_tag [$];

  always #10 clk = ~clk;

  dual_alarm_cmp #(.W(W), .DW(DW), .NCH(2)) dut (.*);

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic longint ext(input logic [W-1:0] v, input logic sg);
    if (sg && v[W-1]) return longint'(v) - (longint'(1) << W);
    return longint'(v);
  endfunction

  function automatic logic [1:0] m_out();
    logic [1:0] o;
    o = {m_st[1] && !ss_hold, m_st[0]};
    return diag_err ? safe_lvl : o;
  endfunction

  task automatic model(input logic [W-1:0] d);
    for (int c = 0; c < 2; c++) begin
      longint v, t, h, w;
      logic f;
      int lim;
      v = ext(d, signed_en); t = ext(thr[c], signed_en);
      h = longint'(hyst[c]); w = longint'(win_width[c]);
      if (win_en[c])
        f = m_st[c] ? (v < t - h || v > t + w + h) : (v >= t && v <= t + w);
      else if (dir_low[c])
        f = m_st[c] ? (v > t + h) : (v < t);
      else
        f = m_st[c] ? (v < t - h) : (v > t);
      if (c == 1 && ss_hold) begin m_st[c] = 0; m_cnt[c] = 0; end
      else if (f) begin
        lim = m_st[c] ? int'(off_dly[c]) : int'(on_dly[c]);
        if (m_cnt[c] == lim) begin m_st[c] = !m_st[c]; m_cnt[c] = 0; end
        else m_cnt[c]++;
      end else m_cnt[c] = 0;
    end
  endtask

  // driver: pushes expectation, monitor pops after the accepting edge
  task automatic send(input logic [W-1:0] d, input logic temp, input string tag);
    @(negedge clk);
    s_data = d; s_is_temp = temp; s_valid = 1;
    if (!temp) model(d);
    q_exp.push_back(m_out());
    q_tag.push_back(tag);
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic hold_set(input logic v);
    @(negedge clk);
    ss_hold = v;
    if (v) begin m_st[1] = 0; m_cnt[1] = 0; end
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (s_valid) begin
        #2;
        if (q_exp.size() > 0) chk(q_tag.pop_front(), alarm, q_exp.pop_front());
      end
    end
  end

  initial begin : watchdog
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    m_st[0] = 0; m_st[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
    thr[0] = 1000; hyst[0] = 100;
    thr[1] = 500;  hyst[1] = 50; dir_low[1] = 1;
    #35 rst_n = 1;
    @(negedge clk);
    chk("R1 reset", alarm, 2'b00);
    chk("R1 ready", {1'b0, s_ready}, 2'b01);
    // R2 / R3 threshold modes with hysteresis edges
    send(900,  0, "R2 below limit");
    send(1000, 0, "R2 equal limit no set");
    send(1001, 0, "R2 set above limit");
    send(900,  0, "R2 at thr-hyst holds");
    send(899,  0, "R2 clear below thr-hyst");
    send(499,  0, "R3 set below limit");
    send(550,  0, "R3 at thr+hyst holds");
    send(551,  0, "R3 clear above thr+hyst");
    send(1200, 0, "R1 only channel 0 sets");
    // R5 temperature sample ignored
    send(0,    1, "R5 temperature ignored");
    send(1200, 0, "R5 main sample still tracked");
    send(800,  0, "R2 clear");
    // R6 / R7 debounce
    on_dly[0] = 2; off_dly[0] = 1;
    send(1100, 0, "R6 first of three");
    send(1100, 0, "R6 second of three");
    send(900,  0, "R6 run broken");
    send(1100, 0, "R6 restart 1");
    send(1100, 0, "R6 restart 2");
    send(1100, 0, "R6 set on third");
    send(800,  0, "R7 first off sample");
    send(950,  0, "R7 run broken");
    send(800,  0, "R7 restart 1");
    send(800,  0, "R7 clear on second");
    on_dly[0] = 0; off_dly[0] = 0;
    // R4 window on channel 1
    win_en[1] = 1; thr[1] = 2000; win_width[1] = 500; hyst[1] = 100;
    send(1999, 0, "R4 below window");
    send(2000, 0, "R4 set at lower bound");
    send(1950, 0, "R4 hysteresis low holds");
    send(2600, 0, "R4 hysteresis high holds");
    send(2601, 0, "R4 clear above band");
    send(2500, 0, "R4 set at upper bound");
    send(1899, 0, "R4 clear below band");
    send(2200, 0, "R4 set again");
    // R8 slave-select hold
    hold_set(1);
    chk("R8 held low", alarm & 2'b10, 2'b00);
    send(2200, 0, "R8 held while sampling");
    hold_set(0);
    chk("R8 released inactive", alarm & 2'b10, 2'b00);
    send(2200, 0, "R8 channel restarts");
    // R9 diagnostic override
    @(negedge clk); diag_err = 1; safe_lvl = 2'b01;
    #1 chk("R9 safe level", alarm, 2'b01);
    send(1500, 0, "R9 override during samples");
    @(negedge clk); diag_err = 0;
    #1 chk("R9 tracking kept", alarm, m_out());
    // R10 signed reading
    send(0, 0, "R10 prepare");
    signed_en = 1; thr[0] = 15'h7F9C; hyst[0] = 10;
    send(10,       0, "R10 positive above negative limit");
    send(15'h7F00, 0, "R10 negative value clears");
    signed_en = 0;
    send(10,       0, "R10 unsigned reading no set");
    repeat (3) @(negedge clk);
    if (q_exp.size() != 0) chk("R5 scoreboard drained", 2'b01, 2'b00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule